// File: doc/BRIEF.md
# Eight-Bit ALU with Persistent Truth Flag

This block is the arithmetic and logic stage of a small processor. A 5-bit operation code chooses one of twenty-two functions over two 8-bit operands. Some functions produce an 8-bit result, and some produce a one-bit truth value. The result is combinational: it follows the operation code and the operands within the same cycle. The truth value goes into a single flag register, which holds it across any number of following data operations. A later conditional step can then test it.

Comparisons are unsigned and write only the flag. Two dedicated codes force the flag high or low. Shift and rotate distances are taken from the second operand. Addition and subtraction wrap silently; there is no carry or overflow indication.

Top module: `tf_alu8`

## Requirements
- R1: Codes 00000, 00001 and 00010 give the bitwise AND, OR and XOR of the two operands on `res_out`. Code 00011 gives the bitwise inverse of operand B alone.
- R2: Code 00100 shifts operand A left and code 00101 shifts it right (logical) by the count in operand B. Zeros fill the vacated bits. A count of 8 or more yields 00000000.
- R3: Code 00110 rotates operand A left and code 00111 rotates it right. The distance is operand B modulo 8.
- R4: Codes 01000 to 01101 compare A with B as unsigned numbers: A>B, A>=B, A<B, A<=B, A==B, A!=B. The outcome appears on `truth_flag` after the next rising clock edge, and `res_out` is 00000000 during these codes.
- R5: Code 01110 loads the flag with (A==0) and code 01111 loads it with (A!=0). Operand B has no effect on either.
- R6: Code 10000 loads the flag with 1 and code 10001 loads it with 0, at the next rising edge. `res_out` is 00000000 during both codes and during codes 01110 and 01111.
- R7: Code 10010 gives A+1 and code 10011 gives A-1 on `res_out`, both modulo 256.
- R8: Code 10100 gives A+B and code 10101 gives A-B on `res_out`, both modulo 256 (for example FF+02=01 and 00-02=FE).
- R9: The codes of R1, R2, R3, R7 and R8 leave `truth_flag` unchanged.
- R10: Codes 10110 to 11111 drive `res_out` to 00000000 and leave `truth_flag` unchanged.
- R11: While `rst_n` is low at a rising edge, the flag is cleared on that edge. This reset takes priority over any flag-writing code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the flag |
| op_code | input | 5 | Operation select |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand (also the shift or rotate count) |
| res_out | output | 8 | Combinational data result |
| truth_flag | output | 1 | Registered truth flag |

## Verification
The data result is due in the same cycle that the code and operands are applied. The bench therefore drives each vector just after a falling edge and compares `res_out` with the reference model a quarter period later, before the rising edge. A flag result is due one rising edge after its vector. The bench compares `truth_flag` at the following falling edge, just before it applies the next vector, and updates its reference flag on the same edge. Because of this, flag persistence across long runs of data operations, as well as reset priority, is checked on every clock.

// File: rtl/tf_alu8_pkg.sv
// Package: operation codes and code-class helpers for the 8-bit ALU.
// Assumes: a 5-bit operation field; code values are fixed by the
// instruction encoding and must not be renumbered.
package tf_alu8_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_AND   = 5'b00000,
        OP_OR    = 5'b00001,
        OP_XOR   = 5'b00010,
        OP_NOTB  = 5'b00011,
        OP_SHL   = 5'b00100,
        OP_SHR   = 5'b00101,
        OP_ROL   = 5'b00110,
        OP_ROR   = 5'b00111,
        OP_GT    = 5'b01000,
        OP_GE    = 5'b01001,
        OP_LT    = 5'b01010,
        OP_LE    = 5'b01011,
        OP_EQ    = 5'b01100,
        OP_NE    = 5'b01101,
        OP_ZERO  = 5'b01110,
        OP_NZERO = 5'b01111,
        OP_SETF  = 5'b10000,
        OP_CLRF  = 5'b10001,
        OP_INC   = 5'b10010,
        OP_DEC   = 5'b10011,
        OP_ADD   = 5'b10100,
        OP_SUB   = 5'b10101
    } op_e;

    // Result source selected by the top-level multiplexer.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_BIT   = 2'd1,
        SRC_SHIFT = 2'd2,
        SRC_ARITH = 2'd3
    } src_e;

    // Map an operation code to the unit that produces its data result.
    function automatic src_e src_of(input logic [OPW-1:0] code);
        if (code <= OP_NOTB)                        return SRC_BIT;
        else if (code <= OP_ROR)                    return SRC_SHIFT;
        else if (code >= OP_INC && code <= OP_SUB)  return SRC_ARITH;
        else                                        return SRC_NONE;
    endfunction

endpackage

// File: rtl/tf_bitwise_unit.sv
// Module: bitwise logic group (AND, OR, XOR, invert of B).
// Assumes: caller only uses the output when the code is in this group;
// other codes produce zero.
module tf_bitwise_unit
    import tf_alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    // Pick the bitwise function named by the code.
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOTB: y = ~b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/tf_shift_unit.sv
// Module: logical shifts and rotates of operand A by a count in B.
// Assumes: W is a power of two, so the rotate distance is the low
// log2(W) bits of B; shifts by W or more give zero.
module tf_shift_unit
    import tf_alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    localparam int CNTW = (W > 1) ? $clog2(W) : 1;

    logic [CNTW-1:0] rot_k;
    logic [2*W-1:0]  dbl_l;
    logic [2*W-1:0]  dbl_r;
    logic [W-1:0]    shl_v;
    logic [W-1:0]    shr_v;

    assign rot_k = b[CNTW-1:0];

    // Shifts: the full count is used, so large counts empty the word.
    always_comb begin
        shl_v = a << b;
        shr_v = a >> b;
    end

    // Rotates: shift a doubled copy and take the wrapped half.
    always_comb begin
        dbl_l = {a, a} << rot_k;
        dbl_r = {a, a} >> rot_k;
    end

    // Select among the four movement results.
    always_comb begin
        case (op)
            OP_SHL:  y = shl_v;
            OP_SHR:  y = shr_v;
            OP_ROL:  y = dbl_l[2*W-1:W];
            OP_ROR:  y = dbl_r[W-1:0];
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/tf_arith_unit.sv
// Module: modulo-2^W increment, decrement, add and subtract.
// Assumes: no carry or overflow is reported; results simply wrap.
module tf_arith_unit
    import tf_alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    logic [W-1:0] addend;
    logic         sub_mode;
    logic [W-1:0] sum;

    // Build the second adder input: +1, -1 (all ones), +B or -B.
    always_comb begin
        sub_mode = 1'b0;
        case (op)
            OP_INC:  addend = W'(1);
            OP_DEC:  addend = '1;
            OP_ADD:  addend = b;
            OP_SUB:  begin addend = ~b; sub_mode = 1'b1; end
            default: addend = '0;
        endcase
    end

    // Single shared adder; subtraction adds the inverse plus one.
    always_comb begin
        sum = a + addend + W'(sub_mode);
        y   = sum;
    end

endmodule

// File: rtl/tf_test_unit.sv
// Module: decides whether a code writes the flag and with what value.
// Assumes: comparisons are unsigned; codes outside the flag group
// request no write.
module tf_test_unit
    import tf_alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           wr_en,
    output logic           wr_val
);

    logic a_gt_b;
    logic a_eq_b;
    logic a_is_0;

    // Two primitive relations; the six comparisons derive from them.
    always_comb begin
        a_gt_b = (a > b);
        a_eq_b = (a == b);
        a_is_0 = (a == '0);
    end

    // Flag write request and value for each flag-group code.
    always_comb begin
        wr_en  = 1'b1;
        wr_val = 1'b0;
        case (op)
            OP_GT:    wr_val = a_gt_b;
            OP_GE:    wr_val = a_gt_b | a_eq_b;
            OP_LT:    wr_val = ~(a_gt_b | a_eq_b);
            OP_LE:    wr_val = ~a_gt_b;
            OP_EQ:    wr_val = a_eq_b;
            OP_NE:    wr_val = ~a_eq_b;
            OP_ZERO:  wr_val = a_is_0;
            OP_NZERO: wr_val = ~a_is_0;
            OP_SETF:  wr_val = 1'b1;
            OP_CLRF:  wr_val = 1'b0;
            default:  wr_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/tf_flag_reg.sv
// Module: the single persistent truth flag.
// Assumes: synchronous active-low reset with priority over writes.
module tf_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    output logic q
);

    // Clear on reset, load on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (wr_en) q <= wr_val;
    end

endmodule

// File: rtl/tf_alu8.sv
// Module: top of the ALU; combinational data result plus a registered
// truth flag.
// Assumes: the operand width is a power of two; unused codes give zero
// and do not touch the flag.
module tf_alu8
    import tf_alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [4:0]     op_code,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic [W-1:0]   res_out,
    output logic           truth_flag
);

    logic [W-1:0] bit_y;
    logic [W-1:0] sh_y;
    logic [W-1:0] ar_y;
    logic         f_we;
    logic         f_val;

    tf_bitwise_unit #(.W(W)) u_bit (
        .op(op_code), .a(opnd_a), .b(opnd_b), .y(bit_y)
    );

    tf_shift_unit #(.W(W)) u_sh (
        .op(op_code), .a(opnd_a), .b(opnd_b), .y(sh_y)
    );

    tf_arith_unit #(.W(W)) u_ar (
        .op(op_code), .a(opnd_a), .b(opnd_b), .y(ar_y)
    );

    tf_test_unit #(.W(W)) u_tst (
        .op(op_code), .a(opnd_a), .b(opnd_b),
        .wr_en(f_we), .wr_val(f_val)
    );

    tf_flag_reg u_flag (
        .clk(clk), .rst_n(rst_n), .wr_en(f_we), .wr_val(f_val),
        .q(truth_flag)
    );

    // Route the unit owning the current code to the data output.
    always_comb begin
        case (src_of(op_code))
            SRC_BIT:   res_out = bit_y;
            SRC_SHIFT: res_out = sh_y;
            SRC_ARITH: res_out = ar_y;
            default:   res_out = '0;
        endcase
    end

endmodule

// File: rtl/tf_alu8_chk.sv
// Module: property checker for tf_alu8, attached by bind.
// Assumes: same port names and width as the top module.
module tf_alu8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [4:0]   op_code,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] res_out,
    input logic         truth_flag
);

    // R9: data-group codes keep the flag.
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code <= 5'b00111 || (op_code >= 5'b10010 && op_code <= 5'b10101))
        |=> $stable(truth_flag));

    // R10: unused codes give zero and keep the flag.
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 5'b10110) |-> (res_out == '0));
    p_unused_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 5'b10110) |=> $stable(truth_flag));

    // R6: forced set and clear.
    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'b10000) |=> truth_flag);
    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'b10001) |=> !truth_flag);

    // R4: flag-group codes drive no data.
    p_cmp_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 5'b01000 && op_code <= 5'b10001) |-> (res_out == '0));

    // R4: equality lands in the flag one edge later.
    p_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'b01100) |=> (truth_flag == ($past(opnd_a) == $past(opnd_b))));

    // R8: difference plus B restores A modulo 2^W.
    p_sub_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'b10101) |-> (W'(res_out + opnd_b) == opnd_a));

    // R11: reset clears the flag.
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> !truth_flag);

endmodule

bind tf_alu8 tf_alu8_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .res_out(res_out), .truth_flag(truth_flag)
);

// File: tb/tf_alu8_test.sv
`timescale 1ns/1ps
module tf_alu8_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_code = 5'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic [7:0] res_out;
    logic       truth_flag;

    int n_vec = 0;
    int n_bad = 0;
    int m_flag = 0;
    bit done = 1'b0;

    tf_alu8 #(.W(8)) uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .res_out(res_out), .truth_flag(truth_flag)
    );

    always #10 clk = ~clk;

    // Reference data result from the requirements.
    function automatic int ref_res(int op, int a, int b);
        int k;
        k = b % 8;
        case (op)
            0:  return a & b;
            1:  return a | b;
            2:  return a ^ b;
            3:  return 255 - b;
            4:  return (b >= 8) ? 0 : ((a << b) & 255);
            5:  return (b >= 8) ? 0 : (a >> b);
            6:  return ((a << k) | (a >> (8 - k))) & 255;
            7:  return ((a >> k) | (a << (8 - k))) & 255;
            18: return (a + 1) % 256;
            19: return (a + 255) % 256;
            20: return (a + b) % 256;
            21: return (a - b + 256) % 256;
            default: return 0;
        endcase
    endfunction

    // Reference next flag.
    function automatic int ref_flag(int op, int a, int b, int cur);
        case (op)
            8:  return int'(a > b);
            9:  return int'(a >= b);
            10: return int'(a < b);
            11: return int'(a <= b);
            12: return int'(a == b);
            13: return int'(a != b);
            14: return int'(a == 0);
            15: return int'(a != 0);
            16: return 1;
            17: return 0;
            default: return cur;
        endcase
    endfunction

    function automatic string tag_of(int op, bit for_flag);
        if (op <= 3)  return for_flag ? "R9" : "R1";
        if (op <= 5)  return for_flag ? "R9" : "R2";
        if (op <= 7)  return for_flag ? "R9" : "R3";
        if (op <= 13) return "R4";
        if (op <= 15) return "R5";
        if (op <= 17) return "R6";
        if (op <= 19) return for_flag ? "R9" : "R7";
        if (op <= 21) return for_flag ? "R9" : "R8";
        return "R10";
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply one vector at a falling edge; result checked mid-low phase,
    // flag checked at the next falling edge.
    task automatic vec(int op, int a, int b);
        op_code = op[4:0];
        opnd_a  = a[7:0];
        opnd_b  = b[7:0];
        #5;
        check(tag_of(op, 1'b0), int'(res_out), ref_res(op, a, b), "result");
        m_flag = ref_flag(op, a, b, m_flag);
        @(negedge clk);
        check(tag_of(op, 1'b1), int'(truth_flag), m_flag, "flag");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset held with a set code active still clears the flag.
        op_code = 5'b10000;
        repeat (3) @(negedge clk);
        check("R11", int'(truth_flag), 0, "flag in reset");
        rst_n = 1'b1;
        m_flag = 0;

        // R1
        vec(0, 8'h81, 8'hFE); vec(1, 8'h81, 8'hFC);
        vec(2, 8'h81, 8'hFC); vec(3, 8'h81, 8'hFC);
        // R2 including counts at and past the width
        vec(4, 8'hF3, 2); vec(5, 8'hF3, 2); vec(4, 8'hF3, 7);
        vec(4, 8'hF3, 8); vec(5, 8'hF3, 9); vec(5, 8'hFF, 255);
        // R3 including counts that wrap
        vec(6, 8'hF3, 2); vec(7, 8'hF3, 2); vec(6, 8'hF3, 8);
        vec(7, 8'hF3, 10); vec(6, 8'h81, 0);
        // R4 at below, equal and above
        for (int op = 8; op <= 13; op++) begin
            vec(op, 8'h20, 8'h40); vec(op, 8'h40, 8'h40);
            vec(op, 8'h41, 8'h40); vec(op, 8'hFF, 8'h00);
        end
        // R5: B varied, must not matter
        vec(14, 0, 8'h50); vec(14, 0, 8'h00); vec(14, 8'h40, 8'h00);
        vec(15, 8'h40, 8'h50); vec(15, 0, 8'hFF); vec(15, 8'h01, 8'h00);
        // R6 then R9: flag survives data codes
        vec(16, 0, 0); vec(19, 8'h12, 0); vec(20, 8'hFF, 2);
        vec(17, 0, 0); vec(18, 8'h42, 0); vec(4, 8'hF3, 1);
        // R7, R8 wrap cases
        vec(18, 8'hFF, 0); vec(19, 8'h00, 0); vec(20, 8'h42, 8'h50);
        vec(21, 8'h50, 8'h42); vec(20, 8'hFF, 8'h02); vec(21, 8'h00, 8'h02);
        // R10 with flag at 1 and at 0
        vec(16, 0, 0);
        for (int op = 22; op <= 31; op++) vec(op, 8'hA5, 8'h5A);
        vec(17, 0, 0);
        for (int op = 22; op <= 31; op++) vec(op, 8'h3C, 8'hC3);
        // Mixed pseudo-random stream
        for (int i = 0; i < 400; i++) begin
            vec(int'($urandom_range(31, 0)), int'($urandom_range(255, 0)),
                int'($urandom_range(255, 0)));
        end
        // R11: reset mid-run with flag high and a set code applied
        vec(16, 0, 0);
        rst_n = 1'b0;
        op_code = 5'b10000;
        @(negedge clk);
        check("R11", int'(truth_flag), 0, "flag after mid-run reset");
        rst_n = 1'b1;
        m_flag = 0;
        vec(12, 8'h07, 8'h07);
        finish_run();
    end

endmodule